// File: doc/BRIEF.md
# Single-Pin Debounce Filter with Edge Event

This block turns one already-synchronized but noisy input pin into a clean level. A slow check tick, divided down from the system clock, compares the raw pin with the held debounced level. A new level is accepted only after a run of consecutive disagreeing samples. Rising and falling changes each have their own run length. Any sample that agrees with the held level restarts the run.

Sampling is idle until the raw pin first disagrees with the held level. From then on it runs on its own schedule, and further raw transitions do not restart it. Sampling stops once a change is accepted. Each accepted change can raise a one-clock event. Whether it does depends on two per-pin settings: an inversion flag, which makes the low state the active one, and a flag that reports both directions. The block also keeps a tracker of which edge it waits for next. It outputs a polarity-corrected copy of the level for consumers that want the active sense.

When the enable is raised, the held level and the tracker are loaded straight from the raw pin, with no filtering and no event.

Top module: `pin_debounce`

## Requirements
- R1: While reset is high, `level_o`, `level_pol_o`, `event_o` and `watch_fall_o` are all 0.
- R2: One clock after `en_i` is seen high following a disabled period, `level_o` and `watch_fall_o` equal `raw_i`, and `event_o` stays 0.
- R3: Sampling begins on the clock where `raw_i` first differs from `level_o`. Samples are then taken every `TICK_DIV` clocks after that clock.
- R4: A low-to-high change is accepted on the `RISE_SAMPLES`-th consecutive high sample, that is `RISE_SAMPLES*TICK_DIV` clocks after sampling begins, and not earlier.
- R5: A high-to-low change is accepted on the `FALL_SAMPLES`-th consecutive low sample, that is `FALL_SAMPLES*TICK_DIV` clocks after sampling begins, and not earlier.
- R6: A sample that agrees with `level_o` restarts the count at the full threshold. A glitch shorter than the threshold changes nothing and raises no event.
- R7: Raw transitions while sampling is running do not restart the sampling schedule.
- R8: On an accepted change, `event_o` is 1 if `both_edges_i` is 1, or if the new level XOR `act_low_i` is 1. Otherwise it is 0.
- R9: `event_o` is high for exactly one clock, in the same clock that `level_o` takes its new value.
- R10: `watch_fall_o` (1 = a falling edge is awaited next) inverts on every accepted change.
- R11: `level_pol_o` equals `level_o` XOR the value `act_low_i` had one clock earlier.
- R12: While `en_i` is low, `level_o` holds, no event fires and sampling stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable; its rising use reloads the level from the pin |
| raw_i | input | 1 | Synchronized raw pin |
| act_low_i | input | 1 | 1 makes the low level the active one |
| both_edges_i | input | 1 | 1 reports changes in both directions |
| level_o | output | 1 | Debounced level |
| level_pol_o | output | 1 | Debounced level corrected for `act_low_i` |
| event_o | output | 1 | One-clock pulse on a qualified change |
| watch_fall_o | output | 1 | 1 when the next awaited edge is falling |

## Verification
The checker watches every cycle for these properties: the event is a single-clock pulse, it appears only when the level moves, its qualification against the two flags, the tracker inverting with each change, the polarity-corrected output, and the level holding while disabled. The exact acceptance clocks for the two asymmetric thresholds, the restart of the count on an agreeing sample, and a mid-run raw toggle leaving the tick phase untouched can only be shown by the bench's timed scenarios. The bench also sweeps all four flag combinations in both change directions.

// File: rtl/dbn_pkg.sv
package dbn_pkg;
  // Sampling phase of the filter
  typedef enum logic [1:0] {
    PH_OFF    = 2'd0,  // disabled, level not yet loaded
    PH_WATCH  = 2'd1,  // loaded, waiting for raw to disagree
    PH_SAMPLE = 2'd2   // periodic sampling in progress
  } dbn_phase_e;
endpackage

// File: rtl/dbn_tick_gen.sv
module dbn_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + PW'(1);
    end
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/dbn_filter.sv
module dbn_filter
  import dbn_pkg::*;
#(
  parameter int RISE_SAMPLES = 2,
  parameter int FALL_SAMPLES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic       raw_i,
  input  logic       tick_i,
  output logic       level_q,
  output logic       level_d,
  output dbn_phase_e phase_q,
  output logic       load_o,
  output logic       start_o,
  output logic       accept_o
);
  localparam int MAX_N = (RISE_SAMPLES > FALL_SAMPLES) ? RISE_SAMPLES : FALL_SAMPLES;
  localparam int CNT_W = $clog2(MAX_N + 1);

  // A high level waits for a fall; a low level waits for a rise.
  function automatic logic [CNT_W-1:0] thr(input logic lvl);
    return lvl ? CNT_W'(FALL_SAMPLES) : CNT_W'(RISE_SAMPLES);
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_d;
  dbn_phase_e       phase_d;
  logic             differ, sample, last;

  always_comb begin
    differ   = (raw_i != level_q);
    load_o   = en_i && (phase_q == PH_OFF);
    start_o  = en_i && (phase_q == PH_WATCH) && differ;
    sample   = en_i && (phase_q == PH_SAMPLE) && tick_i;
    last     = (cnt_q == CNT_W'(1));
    accept_o = sample && differ && last;

    level_d = level_q;
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (!en_i) begin
      phase_d = PH_OFF;
    end else if (load_o) begin
      level_d = raw_i;
      cnt_d   = thr(raw_i);
      phase_d = PH_WATCH;
    end else if (start_o) begin
      phase_d = PH_SAMPLE;
    end else if (sample) begin
      if (!differ) begin
        cnt_d = thr(level_q);
      end else if (last) begin
        level_d = raw_i;
        cnt_d   = thr(raw_i);
        phase_d = PH_WATCH;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
      phase_q <= PH_OFF;
    end else begin
      level_q <= level_d;
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/dbn_event_qual.sv
module dbn_event_qual (
  input  logic clk,
  input  logic rst,
  input  logic act_low_i,
  input  logic both_edges_i,
  input  logic load_i,
  input  logic accept_i,
  input  logic new_val_i,
  input  logic level_d_i,
  output logic event_q,
  output logic watch_fall_q,
  output logic level_pol_q
);
  logic qualified;

  assign qualified = both_edges_i || (new_val_i ^ act_low_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      event_q      <= 1'b0;
      watch_fall_q <= 1'b0;
      level_pol_q  <= 1'b0;
    end else begin
      event_q     <= accept_i && qualified;
      level_pol_q <= level_d_i ^ act_low_i;
      if (load_i) begin
        watch_fall_q <= new_val_i;
      end else if (accept_i) begin
        watch_fall_q <= ~watch_fall_q;
      end
    end
  end
endmodule

// File: rtl/pin_debounce.sv
module pin_debounce
  import dbn_pkg::*;
#(
  parameter int TICK_DIV     = 4,
  parameter int RISE_SAMPLES = 2,
  parameter int FALL_SAMPLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic raw_i,
  input  logic act_low_i,
  input  logic both_edges_i,
  output logic level_o,
  output logic level_pol_o,
  output logic event_o,
  output logic watch_fall_o
);
  dbn_phase_e phase;
  logic       tick, load, start, accept, level_d;

  dbn_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (start),
    .run_i  (phase == PH_SAMPLE),
    .tick_o (tick)
  );

  dbn_filter #(
    .RISE_SAMPLES(RISE_SAMPLES),
    .FALL_SAMPLES(FALL_SAMPLES)
  ) u_filt (
    .clk      (clk),
    .rst      (rst),
    .en_i     (en_i),
    .raw_i    (raw_i),
    .tick_i   (tick),
    .level_q  (level_o),
    .level_d  (level_d),
    .phase_q  (phase),
    .load_o   (load),
    .start_o  (start),
    .accept_o (accept)
  );

  dbn_event_qual u_qual (
    .clk          (clk),
    .rst          (rst),
    .act_low_i    (act_low_i),
    .both_edges_i (both_edges_i),
    .load_i       (load),
    .accept_i     (accept),
    .new_val_i    (raw_i),
    .level_d_i    (level_d),
    .event_q      (event_o),
    .watch_fall_q (watch_fall_o),
    .level_pol_q  (level_pol_o)
  );
endmodule

// File: rtl/pin_debounce_chk.sv
module pin_debounce_chk (
  input logic clk,
  input logic rst,
  input logic en_i,
  input logic act_low_i,
  input logic both_edges_i,
  input logic level_o,
  input logic level_pol_o,
  input logic event_o,
  input logic watch_fall_o
);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    event_o |=> !event_o);

  a_r9_event_on_change: assert property (@(posedge clk) disable iff (rst)
    (event_o && !$past(rst)) |-> (level_o != $past(level_o)));

  a_r8_event_qualified: assert property (@(posedge clk) disable iff (rst)
    (event_o && !$past(rst)) |-> ($past(both_edges_i) || (level_o != $past(act_low_i))));

  a_r10_tracker_flips: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (level_o != $past(level_o))) |-> (watch_fall_o != $past(watch_fall_o)));

  a_r11_pol_level: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (level_pol_o == (level_o ^ $past(act_low_i))));

  a_r12_hold_disabled: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en_i)) |-> ((level_o == $past(level_o)) && !event_o));
endmodule

bind pin_debounce pin_debounce_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .en_i         (en_i),
  .act_low_i    (act_low_i),
  .both_edges_i (both_edges_i),
  .level_o      (level_o),
  .level_pol_o  (level_pol_o),
  .event_o      (event_o),
  .watch_fall_o (watch_fall_o)
);

// File: tb/pin_debounce_test.sv
module pin_debounce_test;
  localparam int DIV  = 4;
  localparam int RISE = 2;
  localparam int FALL = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, raw = 1'b0, al = 1'b0, be = 1'b0;
  logic level, level_pol, evt, watch;

  int n_chk = 0, n_fail = 0, n_evt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pin_debounce #(.TICK_DIV(DIV), .RISE_SAMPLES(RISE), .FALL_SAMPLES(FALL)) uut (
    .clk(clk), .rst(rst), .en_i(en), .raw_i(raw), .act_low_i(al),
    .both_edges_i(be), .level_o(level), .level_pol_o(level_pol),
    .event_o(evt), .watch_fall_o(watch)
  );

  always @(negedge clk) if (!rst && evt) n_evt++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int ev0;
    edges(3);
    // R1 reset state
    chk("R1 level", level, 0); chk("R1 pol", level_pol, 0);
    chk("R1 evt", evt, 0);     chk("R1 watch", watch, 0);
    rst = 1'b0;
    edges(2);
    chk("R12 disabled hold", level, 0);
    // R2 enable loads raw
    raw = 1'b1; en = 1'b1;
    edges(1);
    chk("R2 level", level, 1); chk("R2 watch", watch, 1); chk("R2 evt", evt, 0);
    chk("R11 pol", level_pol, 1);

    // R8 sweep of flags in both directions
    for (int c = 0; c < 4; c++) begin
      al = c[0]; be = c[1];
      edges(1);
      raw = 1'b0;                               // fall, R5
      edges(FALL * DIV);
      chk("R5 not early", level, 1);
      edges(1);
      chk("R5 fall accepted", level, 0);
      chk("R8 fall event", evt, int'(be | (1'b0 ^ al)));
      chk("R10 watch after fall", watch, 0);
      chk("R11 pol", level_pol, int'(1'b0 ^ al));
      edges(1);
      chk("R9 pulse ends", evt, 0);
      raw = 1'b1;                               // rise, R4
      edges(RISE * DIV);
      chk("R4 not early", level, 0);
      edges(1);
      chk("R4 rise accepted", level, 1);
      chk("R8 rise event", evt, int'(be | (1'b1 ^ al)));
      chk("R10 watch after rise", watch, 1);
      edges(1);
      chk("R9 pulse ends", evt, 0);
    end

    // R6 glitch then genuine fall; sampling schedule kept (R3)
    al = 1'b0; be = 1'b1;
    edges(1);
    ev0 = n_evt;
    raw = 1'b0;
    edges(DIV + 1);                             // first low sample taken
    raw = 1'b1;
    edges(DIV);                                 // agreeing sample reloads
    chk("R6 glitch ignored", level, 1);
    chk("R6 no event", n_evt - ev0, 0);
    raw = 1'b0;
    edges(3 * DIV - 1);
    chk("R6 count restarted", level, 1);
    edges(1);
    chk("R6 fall after full run", level, 0);
    chk("R3 event on tick schedule", evt, 1);
    edges(1);

    // R7 mid-run toggle does not restart phase
    raw = 1'b1;
    edges(DIV + 1);
    raw = 1'b0;
    edges(1);
    raw = 1'b1;
    edges(DIV - 2);
    chk("R7 not early", level, 0);
    edges(1);
    chk("R7 schedule kept", level, 1);
    edges(1);

    // R12 disable holds level, then R2 reload
    ev0 = n_evt;
    en = 1'b0; raw = 1'b0;
    edges(3 * FALL * DIV);
    chk("R12 level held", level, 1);
    chk("R12 no event", n_evt - ev0, 0);
    en = 1'b1;
    edges(1);
    chk("R2 reload level", level, 0);
    chk("R2 reload watch", watch, 0);
    chk("R2 reload no event", evt, 0);
    edges(2);
    chk("R2 no event after reload", n_evt - ev0, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule